// File: doc/BRIEF.md
# Beam-Spill Upset Pattern Checker

This block runs configuration-memory upset tests while a chip sits in a pulsed particle beam. Between spills it fills the memory under test through a serial write stream with a fixed test pattern. It then waits for the beam: one spill, or three, depending on a mode input. After the last of those spills ends it streams the memory contents back one bit per cycle and compares each bit with a regenerated copy of the pattern.

Each mismatch is counted against the column it falls in. It is also sorted into one of two totals. A location that failed in the previous pass with the same wrong value counts as a systematic (stuck) error. Any other mismatch counts as a random upset. A per-row history memory holds, for every location, whether it failed last pass and what value it returned. All counters saturate and can be read through a small register port. A clear input zeroes them without disturbing the history.

Top module: `ups_checker`

## Requirements
- R1: After reset and after every completed readback, the block writes ROWS*COLS pattern bits, one per cycle in which `wr_en_o` is high, with stream position k carrying the bit for location k. `wr_en_o` stays low in every cycle that follows a cycle in which `spill_i` was high, so writing pauses during a spill and then resumes where it stopped.
- R2: The pattern is latched at the start of each write phase from `pat_sel_i`. The codes are: 0 = all zero, 1 = all one, 2 = alternating, with even positions 1 and odd positions 0. Code 3 rotates through zero, one and alternating, moving one step per write phase and starting with zero after reset.
- R3: Once writing is complete, readback starts only after the falling edge of the Nth spill whose rising edge was seen after writing ended. N is 1 when the latched `multi_spill_i` is 0 and 3 when it is 1. Spills that occur during writing do not count.
- R4: A readback raises `rd_en_o` for exactly ROWS*COLS cycles. `rd_data_i` is sampled at the clock edge that ends each such cycle and compared with the pattern, which restarts at position 0. A memory that returns the pattern unchanged adds no count.
- R5: Every mismatch at location k increments the counter of column k mod COLS, read at register address k mod COLS.
- R6: A mismatch whose location also mismatched in the previous pass with the same read value increments the systematic total (address COLS+1). Every other mismatch increments the upset total (address COLS).
- R7: Every counter stops at 2^CNT_W-1 and does not wrap.
- R8: A high `clr_i` zeroes all counters at the next clock edge and wins over a simultaneous increment. The pass history is kept.
- R9: `reg_data_o` shows the counter at `reg_addr_i` one clock after the address is applied. Addresses above COLS+1 read 0.
- R10: `done_o` is high for a single cycle after the last row of a readback is processed, and the next write phase begins in the following cycle.
- R11: `wr_en_o` and `rd_en_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spill_i | input | 1 | Beam spill indicator, high while beam is on |
| pat_sel_i | input | 2 | Pattern code, latched at each write phase start |
| multi_spill_i | input | 1 | 0: one spill per pass, 1: three spills per pass |
| clr_i | input | 1 | Clear all counters |
| wr_en_o | output | 1 | Write stream bit valid |
| wr_data_o | output | 1 | Write stream bit |
| rd_en_o | output | 1 | Readback shift request |
| rd_data_i | input | 1 | Readback stream bit |
| reg_addr_i | input | ADDR_W | Counter select |
| reg_data_o | output | CNT_W | Selected counter value, registered |
| done_o | output | 1 | One-cycle pulse at end of readback |

## Verification
The bench models the memory under test with per-location stuck-at-zero and one-pass flip masks. It aims first at the stuck-versus-upset split. A stuck bit must count as an upset on its first failing pass and as systematic on the second. A design that ignored history, or compared only failure flags and not read values, would show wrong totals across the rotating pattern passes. It also gives only two of three required spills and checks that no readback has started, because a counter that triggers early or counts spills during writing would begin too soon. A spill raised mid-write must freeze the write stream. Saturation is forced by an all-stuck memory over two passes, which would wrap the systematic total if the counter were not clamped.

// File: rtl/ups_pkg.sv
package ups_pkg;

  typedef enum logic [1:0] {
    PAT_ZERO = 2'd0,
    PAT_ONE  = 2'd1,
    PAT_ALT  = 2'd2,
    PAT_ROT  = 2'd3
  } pat_sel_e;

  typedef enum logic [2:0] {
    ST_LOAD,
    ST_WRITE,
    ST_ARMED,
    ST_FETCH,
    ST_SHIFT,
    ST_STORE
  } phase_e;

  // Expected bit for a location; only the position's parity matters.
  function automatic logic pat_bit(pat_sel_e p, logic pos_lsb);
    case (p)
      PAT_ONE: pat_bit = 1'b1;
      PAT_ALT: pat_bit = ~pos_lsb;
      default: pat_bit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ups_sat_cnt.sv
module ups_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_o <= '0;
    end else if (inc_i && (cnt_o != '1)) begin
      cnt_o <= cnt_o + W'(1);
    end
  end

endmodule

// File: rtl/ups_hist_ram.sv
module ups_hist_ram #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
    rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/ups_spill_gate.sv
module ups_spill_gate #(
  parameter int MAXN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic spill_i,
  input  logic armed_i,
  input  logic multi_i,
  output logic spill_hi_o,
  output logic go_o
);

  localparam int CW = $clog2(MAXN + 1);

  logic          spill_q;
  logic [CW-1:0] seen;
  logic          rise;
  logic          fall;

  always_ff @(posedge clk) begin
    spill_q <= spill_i;
  end

  assign rise       = spill_i & ~spill_q;
  assign fall       = ~spill_i & spill_q;
  assign spill_hi_o = spill_q;

  // Only edges seen while armed count toward the exposure.
  always_ff @(posedge clk) begin
    if (rst || !armed_i) begin
      seen <= '0;
    end else if (rise && (seen != CW'(MAXN))) begin
      seen <= seen + CW'(1);
    end
  end

  assign go_o = armed_i && fall && (seen == (multi_i ? CW'(MAXN) : CW'(1)));

endmodule

// File: rtl/ups_checker.sv
module ups_checker
  import ups_pkg::*;
#(
  parameter int ROWS   = 256,
  parameter int COLS   = 16,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = $clog2(COLS + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spill_i,
  input  logic [1:0]        pat_sel_i,
  input  logic              multi_spill_i,
  input  logic              clr_i,
  output logic              wr_en_o,
  output logic              wr_data_o,
  output logic              rd_en_o,
  input  logic              rd_data_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  output logic [CNT_W-1:0]  reg_data_o,
  output logic              done_o
);

  localparam int NBITS = ROWS * COLS;
  localparam int IDX_W = $clog2(NBITS);
  localparam int COL_W = $clog2(COLS);
  localparam int ROW_W = IDX_W - COL_W;

  phase_e           st;
  logic [IDX_W-1:0] idx;
  logic [ROW_W-1:0] row_q;
  pat_sel_e         cur_pat;
  logic             multi_q;
  logic [1:0]       rot;
  logic             hist_ok;
  logic [COLS-1:0]  fail_row;
  logic [COLS-1:0]  val_row;
  logic [2*COLS-1:0] hist_rd;
  logic [COLS-1:0]  hist_fail;
  logic [COLS-1:0]  hist_val;

  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  logic             last_bit;
  logic             last_col;
  logic             spill_hi;
  logic             go;
  logic             exp_b;
  logic             mis;
  logic             sys_hit;
  logic             ups_hit;

  logic [CNT_W-1:0] col_cnt [COLS];
  logic [CNT_W-1:0] upset_cnt;
  logic [CNT_W-1:0] sys_cnt;

  assign col      = idx[COL_W-1:0];
  assign row      = idx[IDX_W-1:COL_W];
  assign last_bit = (idx == IDX_W'(NBITS - 1));
  assign last_col = (col == COL_W'(COLS - 1));

  ups_spill_gate #(.MAXN(3)) i_gate (
    .clk       (clk),
    .rst       (rst),
    .spill_i   (spill_i),
    .armed_i   (st == ST_ARMED),
    .multi_i   (multi_q),
    .spill_hi_o(spill_hi),
    .go_o      (go)
  );

  ups_hist_ram #(.DEPTH(ROWS), .WIDTH(2 * COLS)) i_hist (
    .clk    (clk),
    .we_i   (st == ST_STORE),
    .waddr_i(row_q),
    .wdata_i({val_row, fail_row}),
    .raddr_i(row),
    .rdata_o(hist_rd)
  );

  assign hist_fail = hist_rd[COLS-1:0];
  assign hist_val  = hist_rd[2*COLS-1:COLS];

  // Stream strobes come straight from phase and registered spill state.
  assign wr_en_o   = (st == ST_WRITE) && !spill_hi;
  assign rd_en_o   = (st == ST_SHIFT);
  assign exp_b     = pat_bit(cur_pat, idx[0]);
  assign wr_data_o = exp_b;

  assign mis     = rd_en_o && (rd_data_i != exp_b);
  assign sys_hit = mis && hist_ok && hist_fail[col] && (hist_val[col] == rd_data_i);
  assign ups_hit = mis && !sys_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_LOAD;
      idx      <= '0;
      row_q    <= '0;
      cur_pat  <= PAT_ZERO;
      multi_q  <= 1'b0;
      rot      <= 2'd0;
      hist_ok  <= 1'b0;
      fail_row <= '0;
      val_row  <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        ST_LOAD: begin
          if (pat_sel_i == 2'(PAT_ROT)) begin
            cur_pat <= pat_sel_e'(rot);
            rot     <= (rot == 2'd2) ? 2'd0 : rot + 2'd1;
          end else begin
            cur_pat <= pat_sel_e'(pat_sel_i);
          end
          multi_q <= multi_spill_i;
          idx     <= '0;
          st      <= ST_WRITE;
        end
        ST_WRITE: begin
          if (wr_en_o) begin
            idx <= idx + IDX_W'(1);
            if (last_bit) st <= ST_ARMED;
          end
        end
        ST_ARMED: begin
          if (go) st <= ST_FETCH;
        end
        ST_FETCH: begin
          row_q <= row;
          st    <= ST_SHIFT;
        end
        ST_SHIFT: begin
          fail_row[col] <= mis;
          val_row[col]  <= rd_data_i;
          idx           <= idx + IDX_W'(1);
          if (last_col) st <= ST_STORE;
        end
        ST_STORE: begin
          if (idx == '0) begin
            st      <= ST_LOAD;
            done_o  <= 1'b1;
            hist_ok <= 1'b1;
          end else begin
            st <= ST_FETCH;
          end
        end
        default: st <= ST_LOAD;
      endcase
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    ups_sat_cnt #(.W(CNT_W)) i_cnt (
      .clk  (clk),
      .rst  (rst),
      .clr_i(clr_i),
      .inc_i(mis && (col == COL_W'(c))),
      .cnt_o(col_cnt[c])
    );
  end

  ups_sat_cnt #(.W(CNT_W)) i_upset (
    .clk(clk), .rst(rst), .clr_i(clr_i), .inc_i(ups_hit), .cnt_o(upset_cnt)
  );

  ups_sat_cnt #(.W(CNT_W)) i_sys (
    .clk(clk), .rst(rst), .clr_i(clr_i), .inc_i(sys_hit), .cnt_o(sys_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_data_o <= '0;
    end else if (reg_addr_i < ADDR_W'(COLS)) begin
      reg_data_o <= col_cnt[reg_addr_i[COL_W-1:0]];
    end else if (reg_addr_i == ADDR_W'(COLS)) begin
      reg_data_o <= upset_cnt;
    end else if (reg_addr_i == ADDR_W'(COLS + 1)) begin
      reg_data_o <= sys_cnt;
    end else begin
      reg_data_o <= '0;
    end
  end

endmodule

// File: rtl/ups_checker_sva.sv
module ups_checker_sva #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             spill_i,
  input logic             clr_i,
  input logic             wr_en_o,
  input logic             rd_en_o,
  input logic             done_o,
  input logic [CNT_W-1:0] upset_cnt,
  input logic [CNT_W-1:0] sys_cnt
);

  // R1
  wr_pause_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> !$past(spill_i));

  // R11
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en_o && rd_en_o));

  // R7
  sys_sat_chk: assert property (@(posedge clk) disable iff (rst)
    ((sys_cnt == '1) && !clr_i) |=> (sys_cnt == '1));

  // R7
  upset_sat_chk: assert property (@(posedge clk) disable iff (rst)
    ((upset_cnt == '1) && !clr_i) |=> (upset_cnt == '1));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> ((upset_cnt == '0) && (sys_cnt == '0)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (!done_o && !rd_en_o));

endmodule

bind ups_checker ups_checker_sva #(.CNT_W(CNT_W)) i_sva (
  .clk      (clk),
  .rst      (rst),
  .spill_i  (spill_i),
  .clr_i    (clr_i),
  .wr_en_o  (wr_en_o),
  .rd_en_o  (rd_en_o),
  .done_o   (done_o),
  .upset_cnt(upset_cnt),
  .sys_cnt  (sys_cnt)
);

// File: tb/test_ups_checker.sv
`timescale 1ns/1ps
module test_ups_checker;

  localparam int ROWS  = 4;
  localparam int COLS  = 4;
  localparam int CNT_W = 4;
  localparam int AW    = 3;
  localparam int NB    = ROWS * COLS;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          spill_i = 1'b0;
  logic [1:0]    pat_sel_i = 2'd0;
  logic          multi_spill_i = 1'b0;
  logic          clr_i = 1'b0;
  logic          wr_en_o, wr_data_o, rd_en_o, rd_data_i, done_o;
  logic [AW-1:0] reg_addr_i = '0;
  logic [CNT_W-1:0] reg_data_o;

  int n_cmp = 0;
  int n_bad = 0;

  // memory-under-test model
  logic [NB-1:0] memw = '0;
  logic [NB-1:0] stuck0 = '0;
  logic [NB-1:0] flip = '0;
  logic [3:0]    widx, ridx;
  int            wcount, rd_count, ovl;

  always #4 clk = ~clk;

  ups_checker #(.ROWS(ROWS), .COLS(COLS), .CNT_W(CNT_W), .ADDR_W(AW)) i_ups_checker (
    .clk(clk), .rst(rst), .spill_i(spill_i), .pat_sel_i(pat_sel_i),
    .multi_spill_i(multi_spill_i), .clr_i(clr_i), .wr_en_o(wr_en_o),
    .wr_data_o(wr_data_o), .rd_en_o(rd_en_o), .rd_data_i(rd_data_i),
    .reg_addr_i(reg_addr_i), .reg_data_o(reg_data_o), .done_o(done_o)
  );

  always_comb begin
    rd_data_i = memw[ridx];
    if (stuck0[ridx]) rd_data_i = 1'b0;
    if (flip[ridx])   rd_data_i = ~rd_data_i;
  end

  always @(posedge clk) begin
    if (rst) begin
      widx <= '0; ridx <= '0; wcount <= 0; rd_count <= 0; ovl <= 0;
    end else begin
      if (wr_en_o) begin
        memw[widx] <= wr_data_o;
        widx <= widx + 4'd1;
      end
      if (rd_en_o) begin
        ridx <= ridx + 4'd1;
        rd_count <= rd_count + 1;
      end else if (wr_en_o) begin
        rd_count <= 0;
      end
      if (done_o) wcount <= 0;
      else if (wr_en_o) wcount <= wcount + 1;
      if (wr_en_o && rd_en_o) ovl <= ovl + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_reg(input int addr, input int exp, input string tag);
    @(negedge clk);
    reg_addr_i = AW'(addr);
    @(negedge clk);
    chk(tag, int'(reg_data_o), exp);
  endtask

  task automatic wait_write();
    for (int n = 0; n < 1000 && wcount != NB; n++) @(negedge clk);
  endtask

  task automatic do_spill();
    @(negedge clk);
    spill_i = 1'b1;
    repeat (4) @(negedge clk);
    spill_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done_o && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk("R10 done seen", int'(done_o), 1);
    chk("R4 readback length", rd_count, NB);
    @(negedge clk);
    chk("R10 done single cycle", int'(done_o), 0);
    chk("R10 next write starts", int'(wr_en_o), 1);
    chk("R11 no overlap", ovl, 0);
  endtask

  task automatic check_counts(input int c0, input int c1, input int c2, input int c3,
                              input int up, input int sy, input string tag);
    chk_reg(0, c0, {tag, " R5 col0"});
    chk_reg(1, c1, {tag, " R5 col1"});
    chk_reg(2, c2, {tag, " R5 col2"});
    chk_reg(3, c3, {tag, " R5 col3"});
    chk_reg(4, up, {tag, " R6 upset"});
    chk_reg(5, sy, {tag, " R6 systematic"});
  endtask

  task automatic t_reset();
    rst = 1'b1;
    pat_sel_i = 2'd0;
    multi_spill_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("reset wr_en", int'(wr_en_o), 0);
    chk("reset rd_en", int'(rd_en_o), 0);
    chk("reset done", int'(done_o), 0);
    chk("reset reg_data", int'(reg_data_o), 0);
    rst = 1'b0;
  endtask

  // Pass 1: zeros, one spill, write pause during a spill
  task automatic t_zero_pass();
    int frozen;
    for (int n = 0; n < 100 && wcount < 5; n++) @(negedge clk);
    spill_i = 1'b1;
    @(negedge clk);
    frozen = wcount;
    for (int k = 0; k < 3; k++) begin
      chk("R1 write paused in spill", int'(wr_en_o), 0);
      @(negedge clk);
    end
    chk("R1 write position held", wcount, frozen);
    spill_i = 1'b0;
    wait_write();
    chk("R1 write count", wcount, NB);
    chk("R2 zero pattern", int'(memw), 16'h0000);
    pat_sel_i = 2'd1;
    multi_spill_i = 1'b1;
    do_spill();
    wait_done();
    check_counts(0, 0, 0, 0, 0, 0, "R4 clean pass");
  endtask

  // Pass 2: ones, three spills, random flips plus a stuck bit
  task automatic t_three_spill_upsets();
    wait_write();
    chk("R2 one pattern", int'(memw), 16'hFFFF);
    flip = 16'h0420;          // locations 5 and 10
    stuck0 = 16'h0040;        // location 6
    multi_spill_i = 1'b0;
    do_spill();
    do_spill();
    chk("R3 no readback after two of three spills", rd_count, 0);
    chk("R3 still armed", int'(done_o), 0);
    do_spill();
    wait_done();
    flip = '0;
    check_counts(0, 1, 2, 0, 3, 0, "pass2");
  endtask

  // Pass 3: repeat failure becomes systematic, then clear
  task automatic t_systematic_and_clear();
    wait_write();
    chk("R2 one pattern again", int'(memw), 16'hFFFF);
    pat_sel_i = 2'd3;
    do_spill();
    wait_done();
    check_counts(0, 1, 3, 0, 3, 1, "pass3");
    @(negedge clk);
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
    check_counts(0, 0, 0, 0, 0, 0, "R8 after clear");
    chk_reg(6, 0, "R9 unused address");
    chk_reg(7, 0, "R9 unused address top");
  endtask

  // Passes 4-6: rotating pattern with stuck location 6
  task automatic t_rotate();
    wait_write();
    chk("R2 rotate step zero", int'(memw), 16'h0000);
    do_spill();
    wait_done();
    check_counts(0, 0, 0, 0, 0, 0, "rot zero");
    wait_write();
    chk("R2 rotate step one", int'(memw), 16'hFFFF);
    do_spill();
    wait_done();
    check_counts(0, 0, 1, 0, 1, 0, "rot one");
    wait_write();
    chk("R2 rotate step alternating", int'(memw), 16'h5555);
    pat_sel_i = 2'd1;
    do_spill();
    wait_done();
    check_counts(0, 0, 2, 0, 1, 1, "rot alt");
    @(negedge clk);
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
    stuck0 = 16'hFFFF;
  endtask

  // Passes 7-8: whole memory stuck, systematic total saturates
  task automatic t_saturate();
    wait_write();
    do_spill();
    wait_done();
    check_counts(4, 4, 4, 4, 15, 1, "all stuck first");
    wait_write();
    do_spill();
    wait_done();
    check_counts(8, 8, 8, 8, 15, 15, "R7 saturated");
  endtask

  initial begin
    t_reset();
    t_zero_pass();
    t_three_spill_upsets();
    t_systematic_and_clear();
    t_rotate();
    t_saturate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule